// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block learns which older stores a load has conflicted with in the past and, at dispatch, names the single in-flight store that a load (or a store) should wait for. Two tables cooperate. An instruction-address-indexed table maps each load or store to a set number. A second table, indexed by that set number, remembers the instruction number of the youngest store of that set that has been dispatched and has not yet issued. A load whose set has such a store must hold until that store's address is known. Otherwise it may forward or access memory speculatively.

The surrounding core reports three kinds of event. A dispatch asks for a dependence, and for a store it also registers that store as the youngest of its set. A store issue retires the set's entry, but only if the entry still names that store. An ordering violation between a load and a store puts both instructions into one set: a fresh number is allocated, one side joins the other's set, or both move to the lower of their two numbers. A clear input periodically forgets every set membership.

Top module: `ssp_store_set_predictor`

## Requirements
- R1: After reset every membership and every youngest-store entry is invalid and the set allocator holds 0, so no dispatch reports a dependence.
- R2: The membership table is indexed by instruction address bits [9:2]. Addresses that differ only in bits [1:0] or above bit 9 share one entry.
- R3: In the same cycle as a load dispatch, `dep_vld_o` is 1 exactly when the load has a valid set whose youngest-store entry is valid, and `dep_inum_o` then carries that entry's instruction number. Otherwise both outputs are 0.
- R4: A store dispatch with a valid set reports the set's current youngest store as its dependence in the same cycle. From the next cycle on, its own instruction number is the set's youngest store.
- R5: A store dispatch without a valid set reports no dependence and leaves every youngest-store entry unchanged.
- R6: A store issue invalidates its set's youngest-store entry only when that entry holds the issuing store's instruction number. Any other number leaves the entry in place.
- R7: A violation in which neither instruction has a set gives both the allocator's current value. The allocator then advances by one, wrapping from 63 to 0.
- R8: A violation in which only one instruction has a set makes the other instruction join that set, and the allocator does not advance.
- R9: A violation in which both instructions have sets moves both to the numerically smaller set number.
- R10: The clear input invalidates every membership entry. It takes priority over a violation in the same cycle, which is dropped without advancing the allocator, and it leaves the youngest-store entries unchanged.
- R11: When a store dispatch and a store issue address the same youngest-store entry in one cycle, the dispatching store's number is what remains.
- R12: With no dispatch in the cycle, `dep_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Invalidate all set memberships |
| fetch_vld_i | input | 1 | Dispatch of a load or store this cycle |
| fetch_is_store_i | input | 1 | Dispatched instruction is a store |
| fetch_pc_i | input | 32 | Instruction address of the dispatched instruction |
| fetch_inum_i | input | 8 | Instruction number of the dispatched instruction |
| dep_vld_o | output | 1 | Dispatched instruction must wait on a store |
| dep_inum_o | output | 8 | Instruction number of that store |
| iss_vld_i | input | 1 | A store issues this cycle |
| iss_pc_i | input | 32 | Instruction address of the issuing store |
| iss_inum_i | input | 8 | Instruction number of the issuing store |
| viol_vld_i | input | 1 | An ordering violation is reported |
| viol_ld_pc_i | input | 32 | Instruction address of the offending load |
| viol_st_pc_i | input | 32 | Instruction address of the offending store |

## Verification
The assertions assume a single event of each kind per cycle. They also assume the core never issues the store that it dispatches in the same cycle under a different number in the same set, except in the collision that R11 resolves. The stimulus keeps to this by driving at most one dispatch, one issue and one violation per cycle, with unique instruction numbers within each set. The sweep places loads and stores at disjoint table indices, so that every one of the 64 allocated sets, and the wrap back to set 0, can be told apart through the dependence each load later receives.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int unsigned SSP_PC_W     = 32;
    localparam int unsigned SSP_IDX_LO   = 2;
    localparam int unsigned SSP_IDX_W    = 8;
    localparam int unsigned SSP_SSID_W   = 6;
    localparam int unsigned SSP_INUM_W   = 8;

    // Read-port roles on the membership table
    localparam int unsigned PORT_FETCH = 0;
    localparam int unsigned PORT_ISSUE = 1;
    localparam int unsigned PORT_VLD   = 2;
    localparam int unsigned PORT_VST   = 3;
    localparam int unsigned N_RD_PORTS = 4;

    typedef enum logic [2:0] {
        MERGE_IDLE,
        MERGE_ALLOC,
        MERGE_ST_JOINS,
        MERGE_LD_JOINS,
        MERGE_LOWER
    } merge_kind_e;

endpackage

// File: rtl/ssp_id_table.sv
module ssp_id_table #(
    parameter int unsigned PC_W   = ssp_pkg::SSP_PC_W,
    parameter int unsigned IDX_LO = ssp_pkg::SSP_IDX_LO,
    parameter int unsigned IDX_W  = ssp_pkg::SSP_IDX_W,
    parameter int unsigned ID_W   = ssp_pkg::SSP_SSID_W,
    parameter int unsigned NRD    = ssp_pkg::N_RD_PORTS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clear_i,
    input  logic [NRD-1:0][PC_W-1:0]  rd_pc_i,
    output logic [NRD-1:0]            rd_vld_o,
    output logic [NRD-1:0][ID_W-1:0]  rd_id_o,
    input  logic [1:0]                wr_en_i,
    input  logic [1:0][PC_W-1:0]      wr_pc_i,
    input  logic [ID_W-1:0]           wr_id_i
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_q;
    logic [ID_W-1:0]  id_q [DEPTH];

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [IDX_W-1:0] idx;
        assign idx         = rd_pc_i[p][IDX_LO +: IDX_W];
        assign rd_vld_o[p] = vld_q[idx];
        assign rd_id_o[p]  = id_q[idx];
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            vld_q <= '0;
        end else begin
            for (int w = 0; w < 2; w++) begin
                if (wr_en_i[w]) begin
                    vld_q[wr_pc_i[w][IDX_LO +: IDX_W]] <= 1'b1;
                    id_q[wr_pc_i[w][IDX_LO +: IDX_W]]  <= wr_id_i;
                end
            end
        end
    end

endmodule

// File: rtl/ssp_store_table.sv
module ssp_store_table #(
    parameter int unsigned ID_W   = ssp_pkg::SSP_SSID_W,
    parameter int unsigned INUM_W = ssp_pkg::SSP_INUM_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ID_W-1:0]         rd_id_i,
    output logic                    rd_vld_o,
    output logic [INUM_W-1:0]       rd_inum_o,
    input  logic                    wr_en_i,
    input  logic [ID_W-1:0]         wr_id_i,
    input  logic [INUM_W-1:0]       wr_inum_i,
    input  logic                    inv_en_i,
    input  logic [ID_W-1:0]         inv_id_i,
    input  logic [INUM_W-1:0]       inv_inum_i,
    output logic                    inv_hit_o,
    output logic [(1<<ID_W)-1:0]    vld_o
);
    localparam int unsigned DEPTH = 1 << ID_W;

    logic [DEPTH-1:0]  vld_q;
    logic [INUM_W-1:0] inum_q [DEPTH];

    assign rd_vld_o  = vld_q[rd_id_i];
    assign rd_inum_o = inum_q[rd_id_i];
    assign inv_hit_o = inv_en_i && vld_q[inv_id_i] && (inum_q[inv_id_i] == inv_inum_i);
    assign vld_o     = vld_q;

    // Invalidate first, so a same-cycle dispatch write to the entry wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            if (inv_hit_o) begin
                vld_q[inv_id_i] <= 1'b0;
            end
            if (wr_en_i) begin
                vld_q[wr_id_i]  <= 1'b1;
                inum_q[wr_id_i] <= wr_inum_i;
            end
        end
    end

endmodule

// File: rtl/ssp_merge_ctrl.sv
module ssp_merge_ctrl
    import ssp_pkg::*;
#(
    parameter int unsigned ID_W = ssp_pkg::SSP_SSID_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            viol_vld_i,
    input  logic            clear_i,
    input  logic            ld_vld_i,
    input  logic [ID_W-1:0] ld_id_i,
    input  logic            st_vld_i,
    input  logic [ID_W-1:0] st_id_i,
    output logic            wr_ld_o,
    output logic            wr_st_o,
    output logic [ID_W-1:0] wr_id_o,
    output logic [ID_W-1:0] alloc_o
);
    merge_kind_e     kind;
    logic [ID_W-1:0] alloc_q;

    always_comb begin
        kind    = MERGE_IDLE;
        wr_id_o = alloc_q;
        if (viol_vld_i && !clear_i) begin
            unique case ({ld_vld_i, st_vld_i})
                2'b00: begin kind = MERGE_ALLOC;    wr_id_o = alloc_q; end
                2'b10: begin kind = MERGE_ST_JOINS; wr_id_o = ld_id_i; end
                2'b01: begin kind = MERGE_LD_JOINS; wr_id_o = st_id_i; end
                default: begin
                    kind    = MERGE_LOWER;
                    wr_id_o = (ld_id_i < st_id_i) ? ld_id_i : st_id_i;
                end
            endcase
        end
    end

    assign wr_ld_o = (kind == MERGE_ALLOC) || (kind == MERGE_LD_JOINS) || (kind == MERGE_LOWER);
    assign wr_st_o = (kind == MERGE_ALLOC) || (kind == MERGE_ST_JOINS) || (kind == MERGE_LOWER);
    assign alloc_o = alloc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc_q <= '0;
        end else if (kind == MERGE_ALLOC) begin
            alloc_q <= alloc_q + 1'b1;
        end
    end

endmodule

// File: rtl/ssp_store_set_predictor.sv
module ssp_store_set_predictor
    import ssp_pkg::*;
#(
    parameter int unsigned PC_W   = ssp_pkg::SSP_PC_W,
    parameter int unsigned IDX_LO = ssp_pkg::SSP_IDX_LO,
    parameter int unsigned IDX_W  = ssp_pkg::SSP_IDX_W,
    parameter int unsigned SSID_W = ssp_pkg::SSP_SSID_W,
    parameter int unsigned INUM_W = ssp_pkg::SSP_INUM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              fetch_vld_i,
    input  logic              fetch_is_store_i,
    input  logic [PC_W-1:0]   fetch_pc_i,
    input  logic [INUM_W-1:0] fetch_inum_i,
    output logic              dep_vld_o,
    output logic [INUM_W-1:0] dep_inum_o,
    input  logic              iss_vld_i,
    input  logic [PC_W-1:0]   iss_pc_i,
    input  logic [INUM_W-1:0] iss_inum_i,
    input  logic              viol_vld_i,
    input  logic [PC_W-1:0]   viol_ld_pc_i,
    input  logic [PC_W-1:0]   viol_st_pc_i
);
    localparam int unsigned NSETS = 1 << SSID_W;

    logic [N_RD_PORTS-1:0][PC_W-1:0]   sit_pc;
    logic [N_RD_PORTS-1:0]             sit_vld;
    logic [N_RD_PORTS-1:0][SSID_W-1:0] sit_id;
    logic [1:0]                        m_wr_en;
    logic [1:0][PC_W-1:0]              m_wr_pc;
    logic [SSID_W-1:0]                 m_wr_id;
    logic [SSID_W-1:0]                 alloc_q;

    logic              lf_vld;
    logic [INUM_W-1:0] lf_inum;
    logic              st_wr_en;
    logic [SSID_W-1:0] st_idx;
    logic              iss_en;
    logic [SSID_W-1:0] iss_idx;
    logic              iss_hit;
    logic [NSETS-1:0]  lfst_vld;

    assign sit_pc[PORT_FETCH] = fetch_pc_i;
    assign sit_pc[PORT_ISSUE] = iss_pc_i;
    assign sit_pc[PORT_VLD]   = viol_ld_pc_i;
    assign sit_pc[PORT_VST]   = viol_st_pc_i;
    assign m_wr_pc[0]         = viol_ld_pc_i;
    assign m_wr_pc[1]         = viol_st_pc_i;

    ssp_id_table #(
        .PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W), .ID_W(SSID_W), .NRD(N_RD_PORTS)
    ) sit_i (
        .clk(clk), .rst(rst), .clear_i(clear_i),
        .rd_pc_i(sit_pc), .rd_vld_o(sit_vld), .rd_id_o(sit_id),
        .wr_en_i(m_wr_en), .wr_pc_i(m_wr_pc), .wr_id_i(m_wr_id)
    );

    ssp_merge_ctrl #(.ID_W(SSID_W)) merge_i (
        .clk(clk), .rst(rst),
        .viol_vld_i(viol_vld_i), .clear_i(clear_i),
        .ld_vld_i(sit_vld[PORT_VLD]), .ld_id_i(sit_id[PORT_VLD]),
        .st_vld_i(sit_vld[PORT_VST]), .st_id_i(sit_id[PORT_VST]),
        .wr_ld_o(m_wr_en[0]), .wr_st_o(m_wr_en[1]),
        .wr_id_o(m_wr_id), .alloc_o(alloc_q)
    );

    assign st_idx   = sit_id[PORT_FETCH];
    assign st_wr_en = fetch_vld_i && fetch_is_store_i && sit_vld[PORT_FETCH];
    assign iss_idx  = sit_id[PORT_ISSUE];
    assign iss_en   = iss_vld_i && sit_vld[PORT_ISSUE];

    ssp_store_table #(.ID_W(SSID_W), .INUM_W(INUM_W)) lfst_i (
        .clk(clk), .rst(rst),
        .rd_id_i(st_idx), .rd_vld_o(lf_vld), .rd_inum_o(lf_inum),
        .wr_en_i(st_wr_en), .wr_id_i(st_idx), .wr_inum_i(fetch_inum_i),
        .inv_en_i(iss_en), .inv_id_i(iss_idx), .inv_inum_i(iss_inum_i),
        .inv_hit_o(iss_hit), .vld_o(lfst_vld)
    );

    assign dep_vld_o  = fetch_vld_i && sit_vld[PORT_FETCH] && lf_vld;
    assign dep_inum_o = dep_vld_o ? lf_inum : '0;

endmodule

// File: rtl/ssp_store_set_checker.sv
module ssp_store_set_checker #(
    parameter int unsigned SSID_W = ssp_pkg::SSP_SSID_W
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   clear_i,
    input logic                   fetch_vld_i,
    input logic                   dep_vld_o,
    input logic                   viol_vld_i,
    input logic [SSID_W-1:0]      alloc_q,
    input logic                   iss_hit,
    input logic [SSID_W-1:0]      iss_idx,
    input logic                   st_wr_en,
    input logic [SSID_W-1:0]      st_idx,
    input logic [(1<<SSID_W)-1:0] lfst_vld
);
    // R12: no dispatch, no dependence
    p_idle_no_dep_r12: assert property (@(posedge clk) disable iff (rst)
        !fetch_vld_i |-> !dep_vld_o);

    // R10: right after a clear no membership survives
    p_clear_forgets_r10: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> !dep_vld_o);

    // R7: the allocator moves only on a reported violation
    p_alloc_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (!viol_vld_i || clear_i) |=> $stable(alloc_q));

    // R6: a matching issue leaves its entry invalid unless a dispatch rewrote it
    p_issue_retires_r6: assert property (@(posedge clk) disable iff (rst)
        (iss_hit && !(st_wr_en && st_idx == iss_idx)) |=> !lfst_vld[$past(iss_idx)]);

    // R4 / R11: a dispatching store with a set becomes the youngest entry
    p_store_registers_r4: assert property (@(posedge clk) disable iff (rst)
        st_wr_en |=> lfst_vld[$past(st_idx)]);

endmodule

bind ssp_store_set_predictor ssp_store_set_checker #(.SSID_W(SSID_W)) chk_i (.*);

// File: tb/ssp_store_set_predictor_tb_top.sv
module ssp_store_set_predictor_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        clear_i;
    logic        fetch_vld_i, fetch_is_store_i;
    logic [31:0] fetch_pc_i;
    logic [7:0]  fetch_inum_i;
    logic        dep_vld_o;
    logic [7:0]  dep_inum_o;
    logic        iss_vld_i;
    logic [31:0] iss_pc_i;
    logic [7:0]  iss_inum_i;
    logic        viol_vld_i;
    logic [31:0] viol_ld_pc_i, viol_st_pc_i;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ssp_store_set_predictor dut_i (.*);

    function automatic logic [31:0] pc_of(int idx, logic [21:0] up = '0, logic [1:0] lo = 2'b00);
        return {up, idx[7:0], lo};
    endfunction

    task automatic check(string req, logic gv, logic [7:0] gi, logic ev, logic [7:0] ei);
        n_chk++;
        if (gv !== ev || (ev && gi !== ei)) begin
            n_fail++;
            $display("FAIL %s: got vld=%0b inum=%02h, expected vld=%0b inum=%02h", req, gv, gi, ev, ei);
        end
    endtask

    task automatic idle_all();
        clear_i = 0; fetch_vld_i = 0; fetch_is_store_i = 0; fetch_pc_i = '0; fetch_inum_i = '0;
        iss_vld_i = 0; iss_pc_i = '0; iss_inum_i = '0;
        viol_vld_i = 0; viol_ld_pc_i = '0; viol_st_pc_i = '0;
    endtask

    // One dispatch cycle; dependence output is combinational, checked mid-cycle.
    task automatic dispatch(string req, bit st, logic [31:0] pc, logic [7:0] inum, logic ev, logic [7:0] ei);
        @(negedge clk);
        fetch_vld_i = 1; fetch_is_store_i = st; fetch_pc_i = pc; fetch_inum_i = inum;
        #5 check(req, dep_vld_o, dep_inum_o, ev, ei);
        @(posedge clk); #1 idle_all();
    endtask

    task automatic violate(int ld_idx, int st_idx);
        @(negedge clk);
        viol_vld_i = 1; viol_ld_pc_i = pc_of(ld_idx); viol_st_pc_i = pc_of(st_idx);
        @(posedge clk); #1 idle_all();
    endtask

    task automatic issue(int idx, logic [7:0] inum);
        @(negedge clk);
        iss_vld_i = 1; iss_pc_i = pc_of(idx); iss_inum_i = inum;
        @(posedge clk); #1 idle_all();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got running, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle_all();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: empty after reset
        dispatch("R1 load", 0, pc_of(0), 8'h00, 0, 8'h00);
        dispatch("R1 store", 1, pc_of(64), 8'h01, 0, 8'h00);
        dispatch("R1 load after store", 0, pc_of(0), 8'h00, 0, 8'h00);

        // R7 sweep: 64 fresh pairs get sets 0..63
        for (int k = 0; k < 64; k++) violate(k, 64 + k);
        for (int k = 0; k < 64; k++) dispatch("R5 first store in set", 1, pc_of(64 + k), 8'(k), 0, 8'h00);
        for (int k = 0; k < 64; k++) dispatch("R7 distinct sets", 0, pc_of(k), 8'h00, 1, 8'(k));
        // R7 wrap: next allocation is set 0
        violate(128, 129);
        dispatch("R7 wrap to 0", 0, pc_of(128), 8'h00, 1, 8'h00);

        // R4: store sees prior youngest, then replaces it
        dispatch("R4 store dep", 1, pc_of(129), 8'hA0, 1, 8'h00);
        dispatch("R3 load dep", 0, pc_of(0), 8'h00, 1, 8'hA0);
        // R6: mismatching issue ignored, matching issue retires
        issue(129, 8'h11);
        dispatch("R6 mismatch kept", 0, pc_of(0), 8'h00, 1, 8'hA0);
        issue(129, 8'hA0);
        dispatch("R6 match retired", 0, pc_of(0), 8'h00, 0, 8'h00);

        // R11: dispatch and issue on one entry
        dispatch("R4 empty set", 1, pc_of(129), 8'hB0, 0, 8'h00);
        @(negedge clk);
        fetch_vld_i = 1; fetch_is_store_i = 1; fetch_pc_i = pc_of(64); fetch_inum_i = 8'hC0;
        iss_vld_i = 1; iss_pc_i = pc_of(129); iss_inum_i = 8'hB0;
        #5 check("R11 same-cycle dep", dep_vld_o, dep_inum_o, 1, 8'hB0);
        @(posedge clk); #1 idle_all();
        dispatch("R11 dispatch wins", 0, pc_of(0), 8'h00, 1, 8'hC0);

        // R5: setless store leaves entries alone
        dispatch("R5 no set", 1, pc_of(200), 8'h55, 0, 8'h00);
        dispatch("R5 entry unchanged", 0, pc_of(0), 8'h00, 1, 8'hC0);

        // R2: aliasing on bits outside [9:2]
        dispatch("R2 upper alias", 0, pc_of(0, 22'h5, 2'b11), 8'h00, 1, 8'hC0);
        dispatch("R2 other index", 0, pc_of(1, 22'h0, 2'b00) + 32'h4, 8'h00, 1, 8'h02);

        // R8: load joins store's set, then store joins load's set
        violate(210, 64);
        dispatch("R8 load joins", 0, pc_of(210), 8'h00, 1, 8'hC0);
        violate(0, 211);
        dispatch("R8 store joins", 1, pc_of(211), 8'hD0, 1, 8'hC0);
        dispatch("R8 joined dep", 0, pc_of(210), 8'h00, 1, 8'hD0);

        // R9: sets 9 and 5 merge into 5
        violate(9, 69);
        dispatch("R9 lower set", 0, pc_of(9), 8'h00, 1, 8'h05);
        dispatch("R9 old set store", 1, pc_of(73), 8'hE9, 1, 8'h09);
        dispatch("R9 load stays lower", 0, pc_of(9), 8'h00, 1, 8'h05);

        // R7: allocator now at 1
        violate(220, 221);
        dispatch("R7 alloc 1", 1, pc_of(221), 8'hF1, 1, 8'h01);
        dispatch("R7 alloc load", 0, pc_of(220), 8'h00, 1, 8'hF1);

        // R12: no dispatch, no dependence
        @(negedge clk);
        fetch_pc_i = pc_of(220);
        #5 check("R12 idle", dep_vld_o, dep_inum_o, 0, 8'h00);
        @(posedge clk); #1 idle_all();

        // R10: clear beats same-cycle violation
        @(negedge clk);
        clear_i = 1; viol_vld_i = 1; viol_ld_pc_i = pc_of(230); viol_st_pc_i = pc_of(231);
        @(posedge clk); #1 idle_all();
        dispatch("R10 cleared", 0, pc_of(0), 8'h00, 0, 8'h00);
        dispatch("R10 dropped viol store", 1, pc_of(231), 8'h77, 0, 8'h00);
        dispatch("R10 dropped viol load", 0, pc_of(230), 8'h00, 0, 8'h00);
        violate(230, 231);
        dispatch("R10 alloc held, store table kept", 1, pc_of(231), 8'h66, 1, 8'h02);
        dispatch("R10 relearned", 0, pc_of(230), 8'h00, 1, 8'h66);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule